// File: doc/BRIEF.md
# Flash Erase Suspend/Resume Controller

This block is the part of a flash command interface that handles suspending and resuming a block erase. It receives already-decoded bus writes: one strobe and one command byte per cycle. It also receives a pacing strobe from a simplified write state machine. It tracks five conditions:

- idle
- erase running
- erase suspended
- program running inside an erase suspend
- that nested program itself suspended

From that condition it decides which commands are honoured. It drives a status byte, a ready/busy pin and a read-mode select. The read-mode select tells the read path whether reads return the array, the status byte or the query data.

Erase and program progress are modelled by down-counters that move one step per pacing strobe. A suspended operation keeps its count, so a resumed operation continues where it stopped. An erase suspend request is held until the next pacing strobe and takes effect there. An erase resume written while the nested program is still running is held as pending. It is applied in the cycle after that program finishes.

Status byte layout:

| Bit | Meaning |
|-----|---------|
| 7 | Ready |
| 6 | Erase suspended |
| 5 | Erase or sequence error |
| 4 | Program or sequence error |
| 2 | Program suspended |
| 3, 1, 0 | Always 0 |

Read-mode encoding: 0 = array, 1 = status, 2 = query.

Default opcodes (all of them are parameters):

| Command | Opcode |
|---------|--------|
| Read array | 0xFF |
| Read status | 0x70 |
| Read query | 0x98 |
| Clear status | 0x50 |
| Configure | 0xB8 |
| Erase | 0x20 |
| Program | 0x40 |
| Erase suspend | 0xB0 |
| Erase resume | 0xD0 |
| Program suspend | 0xB1 |
| Program resume | 0xD1 |

Default lengths: an erase is 6 steps and a program is 3 steps.

Top module: `flash_esr_ctrl`

## Requirements
- R1: After reset the status byte is 0x80, sts_o is 1 and the read mode is array (0).
- R2: An erase command (0x20) written while idle makes the status byte 0x00, sts_o 0 and the read mode status (1) in the next cycle. The erase returns to 0x80 after ERASE_STEPS pacing strobes that are not consumed by a suspend.
- R3: An erase suspend (0xB0) does nothing visible until the next pacing strobe. In the cycle after that strobe, bits 7 and 6 are both set (status 0xC0) and sts_o is 1.
- R4: Pacing strobes while the erase is suspended do not advance it. After resume, the erase needs exactly its remaining steps to finish.
- R5: An erase resume (0xD0) written while the erase is suspended clears bits 7 and 6, drives sts_o to 0 and sets the read mode to status (1) in the next cycle.
- R6: While the erase is suspended, the following commands are accepted without error:
  - read query (0x98) selects mode 2
  - read status (0x70) selects mode 1
  - clear status (0x50) clears bits 5 and 4
  - configure (0xB8) changes nothing
- R7: While the erase is suspended, any command outside the accepted set sets bits 5 and 4 and otherwise has no effect: the erase stays suspended. Examples are read array (0xFF) and a second erase suspend.
- R8: A program (0x40) written while the erase is suspended gives status 0x40 (bit 7 clear, bit 6 set) and sts_o 0. After PROG_STEPS pacing strobes the status returns to 0xC0.
- R9: A program suspend (0xB1) during the nested program gives status 0xC4 in the next cycle, and pacing strobes then do not advance the program. A program resume (0xD1) returns the status to 0x40.
- R10: An erase resume written while the nested program is busy leaves the status at 0x40. The status is 0xC0 in the cycle after the program finishes and 0x00 one cycle later.
- R11: While idle, erase suspend and erase resume commands have no effect: the status stays 0x80 and the read mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command write strobe, one cycle per write |
| cmd_i | input | CMD_W | Command byte |
| step_i | input | 1 | Pacing strobe from the write state machine model |
| sr_o | output | 8 | Status byte |
| sts_o | output | 1 | Ready (1) or busy (0) pin |
| rd_mode_o | output | 2 | Read-path select: 0 array, 1 status, 2 query |

## Verification
A single erase is driven end to end with one suspend placed mid-way. Pacing strobes are given both before and after the suspend request, which separates a suspend that acts at once from one that waits for the next step. The strobes given while suspended are then counted against the steps the resumed erase still needs. The suspended state is probed with every accepted command and with two rejected ones; this separates the accepted set from the error path and shows that an error leaves the suspend in place. A nested program is suspended and resumed around a paused strobe. A second erase issues its resume while the nested program is busy, which tells an immediate resume apart from a pending one that waits one cycle past program completion.

// File: rtl/flash_esr_pkg.sv
package flash_esr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE, ST_ESUSP, ST_NPROG, ST_NPSUSP
  } esr_state_e;

  typedef enum logic [3:0] {
    C_NONE, C_RD_ARRAY, C_RD_STATUS, C_RD_QUERY, C_CLR_STATUS, C_CONFIG,
    C_ERASE, C_PROGRAM, C_ERS_SUSP, C_ERS_RES, C_PRG_SUSP, C_PRG_RES, C_OTHER
  } cmd_kind_e;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0, RM_STATUS = 2'd1, RM_QUERY = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/flash_esr_decode.sv
module flash_esr_decode
  import flash_esr_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] OP_RD_ARRAY  = 8'hFF,
  parameter logic [CMD_W-1:0] OP_RD_STATUS = 8'h70,
  parameter logic [CMD_W-1:0] OP_RD_QUERY  = 8'h98,
  parameter logic [CMD_W-1:0] OP_CLR       = 8'h50,
  parameter logic [CMD_W-1:0] OP_CONFIG    = 8'hB8,
  parameter logic [CMD_W-1:0] OP_ERASE     = 8'h20,
  parameter logic [CMD_W-1:0] OP_PROGRAM   = 8'h40,
  parameter logic [CMD_W-1:0] OP_ERS_SUSP  = 8'hB0,
  parameter logic [CMD_W-1:0] OP_ERS_RES   = 8'hD0,
  parameter logic [CMD_W-1:0] OP_PRG_SUSP  = 8'hB1,
  parameter logic [CMD_W-1:0] OP_PRG_RES   = 8'hD1
) (
  input  logic             valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_kind_e        kind_o
);
  always_comb begin
    if (!valid_i)                  kind_o = C_NONE;
    else if (cmd_i == OP_RD_ARRAY)  kind_o = C_RD_ARRAY;
    else if (cmd_i == OP_RD_STATUS) kind_o = C_RD_STATUS;
    else if (cmd_i == OP_RD_QUERY)  kind_o = C_RD_QUERY;
    else if (cmd_i == OP_CLR)       kind_o = C_CLR_STATUS;
    else if (cmd_i == OP_CONFIG)    kind_o = C_CONFIG;
    else if (cmd_i == OP_ERASE)     kind_o = C_ERASE;
    else if (cmd_i == OP_PROGRAM)   kind_o = C_PROGRAM;
    else if (cmd_i == OP_ERS_SUSP)  kind_o = C_ERS_SUSP;
    else if (cmd_i == OP_ERS_RES)   kind_o = C_ERS_RES;
    else if (cmd_i == OP_PRG_SUSP)  kind_o = C_PRG_SUSP;
    else if (cmd_i == OP_PRG_RES)   kind_o = C_PRG_RES;
    else                            kind_o = C_OTHER;
  end
endmodule

// File: rtl/flash_esr_step_cnt.sv
module flash_esr_step_cnt #(
  parameter int STEPS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic adv_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= CNT_W'(STEPS);
    else if (adv_i && cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flash_esr_ctrl.sv
module flash_esr_ctrl
  import flash_esr_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int ERASE_STEPS = 6,
  parameter int PROG_STEPS  = 3,
  parameter logic [CMD_W-1:0] OP_RD_ARRAY  = 8'hFF,
  parameter logic [CMD_W-1:0] OP_RD_STATUS = 8'h70,
  parameter logic [CMD_W-1:0] OP_RD_QUERY  = 8'h98,
  parameter logic [CMD_W-1:0] OP_CLR       = 8'h50,
  parameter logic [CMD_W-1:0] OP_CONFIG    = 8'hB8,
  parameter logic [CMD_W-1:0] OP_ERASE     = 8'h20,
  parameter logic [CMD_W-1:0] OP_PROGRAM   = 8'h40,
  parameter logic [CMD_W-1:0] OP_ERS_SUSP  = 8'hB0,
  parameter logic [CMD_W-1:0] OP_ERS_RES   = 8'hD0,
  parameter logic [CMD_W-1:0] OP_PRG_SUSP  = 8'hB1,
  parameter logic [CMD_W-1:0] OP_PRG_RES   = 8'hD1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             step_i,
  output logic [7:0]       sr_o,
  output logic             sts_o,
  output logic [1:0]       rd_mode_o
);
  esr_state_e state_q, state_d;
  rd_mode_e   mode_q, mode_d;
  cmd_kind_e  kind;
  logic susp_req_q, susp_req_d;
  logic pend_q, pend_d;
  logic err_e_q, err_e_d, err_p_q, err_p_d;
  logic ers_last, prg_last;
  logic ers_load, ers_adv, ers_done;
  logic prg_load, prg_adv, prg_done;

  flash_esr_decode #(
    .CMD_W(CMD_W), .OP_RD_ARRAY(OP_RD_ARRAY), .OP_RD_STATUS(OP_RD_STATUS),
    .OP_RD_QUERY(OP_RD_QUERY), .OP_CLR(OP_CLR), .OP_CONFIG(OP_CONFIG),
    .OP_ERASE(OP_ERASE), .OP_PROGRAM(OP_PROGRAM), .OP_ERS_SUSP(OP_ERS_SUSP),
    .OP_ERS_RES(OP_ERS_RES), .OP_PRG_SUSP(OP_PRG_SUSP), .OP_PRG_RES(OP_PRG_RES)
  ) u_dec (
    .valid_i(cmd_valid_i), .cmd_i(cmd_i), .kind_o(kind)
  );

  // suspend request consumes the step it lands on
  assign ers_load = (state_q == ST_IDLE) && (kind == C_ERASE);
  assign ers_adv  = step_i && (state_q == ST_ERASE) && !susp_req_q;
  assign ers_done = ers_adv && ers_last;
  assign prg_load = (state_q == ST_ESUSP) && !pend_q && (kind == C_PROGRAM);
  assign prg_adv  = step_i && (state_q == ST_NPROG) && (kind != C_PRG_SUSP);
  assign prg_done = prg_adv && prg_last;

  flash_esr_step_cnt #(.STEPS(ERASE_STEPS)) u_ers_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ers_load), .adv_i(ers_adv),
    .last_o(ers_last)
  );

  flash_esr_step_cnt #(.STEPS(PROG_STEPS)) u_prg_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(prg_load), .adv_i(prg_adv),
    .last_o(prg_last)
  );

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    susp_req_d = susp_req_q;
    pend_d     = pend_q;
    err_e_d    = err_e_q;
    err_p_d    = err_p_q;
    unique case (state_q)
      ST_IDLE: begin
        unique case (kind)
          C_ERASE:      begin state_d = ST_ERASE; mode_d = RM_STATUS; end
          C_RD_ARRAY:   mode_d = RM_ARRAY;
          C_RD_STATUS:  mode_d = RM_STATUS;
          C_RD_QUERY:   mode_d = RM_QUERY;
          C_CLR_STATUS: begin err_e_d = 1'b0; err_p_d = 1'b0; end
          default: ;
        endcase
      end
      ST_ERASE: begin
        if (kind == C_ERS_SUSP)  susp_req_d = 1'b1;
        if (kind == C_RD_STATUS) mode_d = RM_STATUS;
        if (step_i && susp_req_q) begin
          state_d    = ST_ESUSP;
          susp_req_d = 1'b0;
        end else if (ers_done) begin
          state_d = ST_IDLE;
        end
      end
      ST_ESUSP: begin
        if (pend_q) begin
          state_d = ST_ERASE;
          pend_d  = 1'b0;
        end else begin
          unique case (kind)
            C_NONE:       ;
            C_CONFIG:     ;
            C_RD_QUERY:   mode_d = RM_QUERY;
            C_RD_STATUS:  mode_d = RM_STATUS;
            C_CLR_STATUS: begin err_e_d = 1'b0; err_p_d = 1'b0; end
            C_ERS_RES:    begin state_d = ST_ERASE; mode_d = RM_STATUS; end
            C_PROGRAM:    begin state_d = ST_NPROG; mode_d = RM_STATUS; end
            default:      begin err_e_d = 1'b1; err_p_d = 1'b1; end
          endcase
        end
      end
      ST_NPROG: begin
        if (kind == C_ERS_RES)   pend_d = 1'b1;
        if (kind == C_RD_STATUS) mode_d = RM_STATUS;
        if (kind == C_PRG_SUSP)  state_d = ST_NPSUSP;
        else if (prg_done)       state_d = ST_ESUSP;
      end
      ST_NPSUSP: begin
        unique case (kind)
          C_PRG_RES:    state_d = ST_NPROG;
          C_ERS_RES:    pend_d  = 1'b1;
          C_RD_STATUS:  mode_d  = RM_STATUS;
          C_CLR_STATUS: begin err_e_d = 1'b0; err_p_d = 1'b0; end
          default: ;
        endcase
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= RM_ARRAY;
      susp_req_q <= 1'b0;
      pend_q     <= 1'b0;
      err_e_q    <= 1'b0;
      err_p_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      susp_req_q <= susp_req_d;
      pend_q     <= pend_d;
      err_e_q    <= err_e_d;
      err_p_q    <= err_p_d;
    end
  end

  logic ready, ers_susp, prg_susp;
  assign ready    = (state_q == ST_IDLE) || (state_q == ST_ESUSP) ||
                    (state_q == ST_NPSUSP);
  assign ers_susp = (state_q == ST_ESUSP) || (state_q == ST_NPROG) ||
                    (state_q == ST_NPSUSP);
  assign prg_susp = (state_q == ST_NPSUSP);

  assign sr_o      = {ready, ers_susp, err_e_q, err_p_q, 1'b0, prg_susp, 2'b00};
  assign sts_o     = ready;
  assign rd_mode_o = mode_q;
endmodule

// File: rtl/flash_esr_chk.sv
module flash_esr_chk #(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] OP_RD_ARRAY = 8'hFF,
  parameter logic [CMD_W-1:0] OP_ERS_RES  = 8'hD0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [CMD_W-1:0] cmd_i,
  input logic             step_i,
  input logic             rdy_i,
  input logic             esus_i,
  input logic             eerr_i,
  input logic             perr_i,
  input logic             psus_i
);
  logic in_esusp;
  assign in_esusp = rdy_i && esus_i && !psus_i;

  // R3: suspend only lands on a pacing strobe
  p_susp_on_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(esus_i) |-> $past(step_i));

  // R3: ready and erase-suspended appear together
  p_susp_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(esus_i) |-> rdy_i);

  p_resume_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_esusp && cmd_valid_i && cmd_i == OP_ERS_RES) |=> (!rdy_i && !esus_i));

  p_bad_cmd_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_esusp && cmd_valid_i && cmd_i == OP_RD_ARRAY) |=> (eerr_i && perr_i && esus_i));

  // R10: nested program never jumps straight back to erase
  p_pend_waits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esus_i && !rdy_i) |=> esus_i);

  p_psusp_inside_esusp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psus_i |-> (esus_i && rdy_i));
endmodule

bind flash_esr_ctrl flash_esr_chk #(
  .CMD_W(CMD_W), .OP_RD_ARRAY(OP_RD_ARRAY), .OP_ERS_RES(OP_ERS_RES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .step_i(step_i), .rdy_i(sr_o[7]), .esus_i(sr_o[6]), .eerr_i(sr_o[5]),
  .perr_i(sr_o[4]), .psus_i(sr_o[2])
);

// File: tb/sim_flash_esr_ctrl.sv
module sim_flash_esr_ctrl;
  localparam logic [7:0] C_RDA = 8'hFF, C_RDS = 8'h70, C_RDQ = 8'h98,
    C_CLR = 8'h50, C_CFG = 8'hB8, C_ERS = 8'h20, C_PRG = 8'h40,
    C_ESP = 8'hB0, C_ERR = 8'hD0, C_PSP = 8'hB1, C_PRR = 8'hD1;

  logic clk = 1'b0, rst_n = 1'b0, cv = 1'b0, stp = 1'b0;
  logic [7:0] cmd = '0;
  logic [7:0] sr;
  logic sts;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string req; logic [7:0] sr; logic [1:0] mode; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  flash_esr_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv), .cmd_i(cmd),
    .step_i(stp), .sr_o(sr), .sts_o(sts), .rd_mode_o(mode)
  );

  task automatic expect_st(input string req, input logic [7:0] s, input logic [1:0] m);
    exp_t e;
    e.req = req; e.sr = s; e.mode = m;
    q.push_back(e);
  endtask

  task automatic wr(input logic [7:0] op);
    cv = 1'b1; cmd = op;
    @(posedge clk); @(negedge clk);
    cv = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      stp = 1'b1;
      @(posedge clk); @(negedge clk);
      stp = 1'b0;
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  // monitor: outputs are purely registered, so comparing at the negedge is safe
  initial forever begin
    exp_t e;
    wait (q.size() > 0);
    e = q.pop_front();
    checks++;
    if (sr !== e.sr || sts !== e.sr[7] || mode !== e.mode) begin
      errors++;
      $display("FAIL %s: sr=%h sts=%b mode=%0d expected sr=%h sts=%b mode=%0d",
               e.req, sr, sts, mode, e.sr, e.sr[7], e.mode);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_st("R1", 8'h80, 2'd0);
    rst_n = 1'b1;
    idle();
    // R11: suspend/resume in idle ignored
    wr(C_ESP); wr(C_ERR);
    expect_st("R11", 8'h80, 2'd0);
    // R2: start erase
    wr(C_ERS);
    expect_st("R2", 8'h00, 2'd1);
    step(2);
    expect_st("R2", 8'h00, 2'd1);
    // R3: suspend waits for step
    wr(C_ESP);
    expect_st("R3", 8'h00, 2'd1);
    idle();
    expect_st("R3", 8'h00, 2'd1);
    step(1);
    expect_st("R3", 8'hC0, 2'd1);
    // R4: paused
    step(3);
    expect_st("R4", 8'hC0, 2'd1);
    // R6: accepted set
    wr(C_RDQ);
    expect_st("R6", 8'hC0, 2'd2);
    wr(C_CFG);
    expect_st("R6", 8'hC0, 2'd2);
    wr(C_RDS);
    expect_st("R6", 8'hC0, 2'd1);
    // R7: rejected commands
    wr(C_RDA);
    expect_st("R7", 8'hF0, 2'd1);
    wr(C_CLR);
    expect_st("R6", 8'hC0, 2'd1);
    wr(C_ESP);
    expect_st("R7", 8'hF0, 2'd1);
    wr(C_CLR);
    // R8/R9: nested program with its own suspend
    wr(C_PRG);
    expect_st("R8", 8'h40, 2'd1);
    step(2);
    expect_st("R8", 8'h40, 2'd1);
    wr(C_PSP);
    expect_st("R9", 8'hC4, 2'd1);
    step(1);
    expect_st("R9", 8'hC4, 2'd1);
    wr(C_PRR);
    expect_st("R9", 8'h40, 2'd1);
    step(1);
    expect_st("R8", 8'hC0, 2'd1);
    // R5: resume restores status mode
    wr(C_RDQ);
    expect_st("R6", 8'hC0, 2'd2);
    wr(C_ERR);
    expect_st("R5", 8'h00, 2'd1);
    // R4: 4 steps remain
    step(3);
    expect_st("R4", 8'h00, 2'd1);
    step(1);
    expect_st("R4", 8'h80, 2'd1);
    // R10: pending resume
    wr(C_ERS);
    step(1);
    wr(C_ESP);
    step(1);
    expect_st("R10", 8'hC0, 2'd1);
    wr(C_PRG);
    wr(C_ERR);
    expect_st("R10", 8'h40, 2'd1);
    step(2);
    expect_st("R10", 8'h40, 2'd1);
    step(1);
    expect_st("R10", 8'hC0, 2'd1);
    idle();
    expect_st("R10", 8'h00, 2'd1);
    step(4);
    expect_st("R4", 8'h00, 2'd1);
    step(1);
    expect_st("R4", 8'h80, 2'd1);
    wait (q.size() == 0);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule